// File: doc/BRIEF.md
# Conditional Skip Evaluator

This unit decides, for a 16-bit two's-complement accumulator machine, how many of the following instructions the sequencer must step over: none, one or two. Each time `in_valid` is high it takes the instruction word, the two accumulators, the fetched memory operand, the overflow latch, sixteen panel switches, the index register and the flag that says whether indexing is routed through accumulator B. One clock later it presents the skip count together with any value the operation produces: the incremented B accumulator, the incremented memory word, the index register plus a small constant, or a request to clear the overflow latch. Each value has its own write enable.

The sequencer adds `skip_cnt` to its program counter and commits whichever write enable is raised. Instruction fetch, the memory bus and the program counter itself stay outside the block. The input side is a plain valid strobe with no ready. The block has no back-pressure and can take a new operation on every clock, so a stream of back-to-back strobes produces back-to-back results in the same order, each exactly one cycle later. A strobe whose instruction is not recognised still produces a result pulse, with a skip of zero and no write.

Bit numbers below count from the least significant bit, so bit 15 is the sign. The major opcode is `instr[15:10]`. Major 00 (octal) marks a sub-function operation, whose code sits in `instr[5:0]`.

Top module: `skip_eval`

## Requirements
- R1: A cycle with `in_valid` high makes `out_valid` high for exactly one cycle on the next clock, with the result for that strobe; a cycle with `in_valid` low makes `out_valid` low on the next clock; strobes on consecutive cycles give results on consecutive cycles in order.
- R2: While `out_valid` is low, `skip_cnt` is 0 and every write enable is low. At most one write enable is high at a time. An instruction that matches no code listed in R3 to R11 gives skip 0 and no write.
- R3: Major 15 (octal) compares `acc_a` with `mem_word` as signed numbers: skip 0 when A is less, 1 when equal, 2 when A is greater.
- R4: Sub-function 21 (octal) tests the sign of A three ways: skip 0 when bit 15 is set, 1 when A is zero, 2 when A is positive and nonzero.
- R5: Sub-functions 22, 23, 24 and 32 (octal) skip 1 respectively when A is zero, when bit 15 is set, when bit 15 is clear (zero counts as positive), and when bits 15 and 14 differ; otherwise they skip 0.
- R6: Sub-function 25 (octal) skips 1 when the overflow latch is clear; when the latch is set it skips 0 and raises `ovf_clr`.
- R7: Sub-function 26 (octal) raises `b_we` with `b_next` = `acc_b`+1 modulo 2^16, and skips 1 when bit 15 of that result is clear.
- R8: Major 14 (octal) raises `mem_we` with `mem_next` = `mem_word`+1 modulo 2^16, and skips 1 only when that result is exactly zero.
- R9: Major 13 (octal) selects switch `panel_sw[instr[3:0]]` and skips 1 when that switch is 0, otherwise 0.
- R10: Sub-function 51 (octal) raises `idx_we` with `idx_next` = `idx_reg` plus the unsigned 4-bit field `instr[9:6]`, and skips 1 when bit 15 of the result is clear. With a field of 0 the index is returned unchanged.
- R11: Sub-function 50 (octal) skips 1 when `idx_on_b` is high, otherwise 0.
- R12: After reset and until the first strobe, `out_valid`, `skip_cnt` and every write enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| instr | input | 16 | Instruction word |
| acc_a | input | 16 | Accumulator A |
| acc_b | input | 16 | Accumulator B |
| mem_word | input | 16 | Memory operand |
| ovf_latch | input | 1 | Current overflow latch |
| panel_sw | input | 16 | Panel switches, 1 = set |
| idx_reg | input | 16 | Index register |
| idx_on_b | input | 1 | Indexing routed through accumulator B |
| out_valid | output | 1 | Result pulse |
| skip_cnt | output | 2 | Instructions to skip (0, 1 or 2) |
| b_we | output | 1 | Write `b_next` into accumulator B |
| b_next | output | 16 | Incremented B |
| mem_we | output | 1 | Write `mem_next` back to memory |
| mem_next | output | 16 | Incremented memory word |
| idx_we | output | 1 | Write `idx_next` into the index register |
| idx_next | output | 16 | Index plus the 4-bit field |
| ovf_clr | output | 1 | Clear the overflow latch |

## Verification
The bench aims at the signed/unsigned split in the compare: an operand of 0xFFFF against 1 must skip 0, where an unsigned compare would skip 2. It also covers the difference between "zero or positive" and "exactly zero" in the two increment operations: memory at 0 incremented to 1 must not skip, while B at 0xFFFF wrapping to 0 must. Sign tests are driven with zero and 0x8000 to catch a design that treats zero as negative or tests the wrong bit for normalisation. The switch select and the index field are driven at their extreme positions, including a field of 0 and switch 15, to catch a swapped or shifted field. Back-to-back strobes and unknown codes expose a design that drops results or raises stray writes.

// File: rtl/skip_pkg.sv
package skip_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CMP3,
    OP_SGN3,
    OP_ZERO,
    OP_NEG,
    OP_POS,
    OP_NORM,
    OP_NOVF,
    OP_INCB,
    OP_INCM,
    OP_SENSE,
    OP_IDXN,
    OP_IPTR
  } skip_op_e;

  // major opcodes, instr[15:10]
  localparam logic [5:0] MAJ_SUBFN  = 6'o00;
  localparam logic [5:0] MAJ_SENSE  = 6'o13;
  localparam logic [5:0] MAJ_INCMEM = 6'o14;
  localparam logic [5:0] MAJ_CMPMEM = 6'o15;

  // sub-function codes, instr[5:0] when major is MAJ_SUBFN
  localparam logic [5:0] SUB_SIGN3 = 6'o21;
  localparam logic [5:0] SUB_ZERO  = 6'o22;
  localparam logic [5:0] SUB_NEG   = 6'o23;
  localparam logic [5:0] SUB_POS   = 6'o24;
  localparam logic [5:0] SUB_NOOVF = 6'o25;
  localparam logic [5:0] SUB_INCB  = 6'o26;
  localparam logic [5:0] SUB_NORM  = 6'o32;
  localparam logic [5:0] SUB_IPTR  = 6'o50;
  localparam logic [5:0] SUB_IDXN  = 6'o51;

  typedef struct packed {
    logic [1:0] skip;
    logic       b_we;
    logic       m_we;
    logic       x_we;
    logic       ovf_clr;
  } skip_res_t;

endpackage

// File: rtl/skip_decode.sv
module skip_decode
  import skip_pkg::*;
#(
  parameter int IW    = 16,
  parameter int NW    = 4,
  parameter int N_LSB = 6,
  parameter int SEL_W = 4
) (
  input  logic [IW-1:0]    instr,
  output skip_op_e         op,
  output logic [NW-1:0]    n_val,
  output logic [SEL_W-1:0] sel
);
  localparam int MAJ_LSB = IW - 6;

  logic [5:0] major;
  logic [5:0] sub;

  assign major = instr[IW-1:MAJ_LSB];
  assign sub   = instr[5:0];
  assign n_val = instr[N_LSB+NW-1:N_LSB];
  assign sel   = instr[SEL_W-1:0];

  always_comb begin
    op = OP_NONE;
    unique case (major)
      MAJ_CMPMEM: op = OP_CMP3;
      MAJ_INCMEM: op = OP_INCM;
      MAJ_SENSE:  op = OP_SENSE;
      MAJ_SUBFN: begin
        case (sub)
          SUB_SIGN3: op = OP_SGN3;
          SUB_ZERO:  op = OP_ZERO;
          SUB_NEG:   op = OP_NEG;
          SUB_POS:   op = OP_POS;
          SUB_NOOVF: op = OP_NOVF;
          SUB_INCB:  op = OP_INCB;
          SUB_NORM:  op = OP_NORM;
          SUB_IPTR:  op = OP_IPTR;
          SUB_IDXN:  op = OP_IDXN;
          default:   op = OP_NONE;
        endcase
      end
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/skip_incr.sv
module skip_incr #(
  parameter int DW = 16,
  parameter int NW = 4
) (
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] m_in,
  input  logic [DW-1:0] x_in,
  input  logic [NW-1:0] n_val,
  output logic [DW-1:0] b_sum,
  output logic [DW-1:0] m_sum,
  output logic [DW-1:0] x_sum
);
  localparam int LANES = 3;

  logic [DW-1:0] base [LANES];
  logic [DW-1:0] step [LANES];
  logic [DW-1:0] sum  [LANES];

  assign base[0] = b_in;
  assign step[0] = DW'(1);
  assign base[1] = m_in;
  assign step[1] = DW'(1);
  assign base[2] = x_in;
  assign step[2] = {{(DW-NW){1'b0}}, n_val};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sum[g] = base[g] + step[g];
  end

  assign b_sum = sum[0];
  assign m_sum = sum[1];
  assign x_sum = sum[2];
endmodule

// File: rtl/skip_test.sv
module skip_test
  import skip_pkg::*;
#(
  parameter int DW         = 16,
  parameter int NSW        = 16,
  parameter int SEL_W      = 4,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  skip_op_e         op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    m,
  input  logic             ovf,
  input  logic [NSW-1:0]   sw,
  input  logic [SEL_W-1:0] sel,
  input  logic             ptr_b,
  input  logic [DW-1:0]    b_sum,
  input  logic [DW-1:0]    m_sum,
  input  logic [DW-1:0]    x_sum,
  output skip_res_t        res
);
  logic a_lt, a_eq, a_zero, a_neg, a_norm, sw_bit;

  if (SIGNED_CMP) begin : g_signed
    assign a_lt = $signed(a) < $signed(m);
  end else begin : g_unsigned
    assign a_lt = a < m;
  end

  assign a_eq   = (a == m);
  assign a_zero = (a == '0);
  assign a_neg  = a[DW-1];
  assign a_norm = a[DW-1] ^ a[DW-2];
  assign sw_bit = sw[sel];

  function automatic logic [1:0] one_if(input logic c);
    return c ? 2'd1 : 2'd0;
  endfunction

  always_comb begin
    res = '0;
    case (op)
      OP_CMP3:  res.skip = a_lt ? 2'd0 : (a_eq ? 2'd1 : 2'd2);
      OP_SGN3:  res.skip = a_neg ? 2'd0 : (a_zero ? 2'd1 : 2'd2);
      OP_ZERO:  res.skip = one_if(a_zero);
      OP_NEG:   res.skip = one_if(a_neg);
      OP_POS:   res.skip = one_if(!a_neg);
      OP_NORM:  res.skip = one_if(a_norm);
      OP_NOVF: begin
        res.skip    = one_if(!ovf);
        res.ovf_clr = ovf;
      end
      OP_INCB: begin
        res.skip = one_if(!b_sum[DW-1]);
        res.b_we = 1'b1;
      end
      OP_INCM: begin
        res.skip = one_if(m_sum == '0);
        res.m_we = 1'b1;
      end
      OP_SENSE: res.skip = one_if(!sw_bit);
      OP_IDXN: begin
        res.skip = one_if(!x_sum[DW-1]);
        res.x_we = 1'b1;
      end
      OP_IPTR:  res.skip = one_if(ptr_b);
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NSW = 16,
  parameter int NW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  instr,
  input  logic [DW-1:0]  acc_a,
  input  logic [DW-1:0]  acc_b,
  input  logic [DW-1:0]  mem_word,
  input  logic           ovf_latch,
  input  logic [NSW-1:0] panel_sw,
  input  logic [DW-1:0]  idx_reg,
  input  logic           idx_on_b,
  output logic           out_valid,
  output logic [1:0]     skip_cnt,
  output logic           b_we,
  output logic [DW-1:0]  b_next,
  output logic           mem_we,
  output logic [DW-1:0]  mem_next,
  output logic           idx_we,
  output logic [DW-1:0]  idx_next,
  output logic           ovf_clr
);
  localparam int SEL_W = $clog2(NSW);

  skip_op_e         op;
  logic [NW-1:0]    n_val;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    b_sum, m_sum, x_sum;
  skip_res_t        res;

  skip_decode #(.IW(DW), .NW(NW), .N_LSB(6), .SEL_W(SEL_W)) u_dec (
    .instr (instr),
    .op    (op),
    .n_val (n_val),
    .sel   (sel)
  );

  skip_incr #(.DW(DW), .NW(NW)) u_inc (
    .b_in  (acc_b),
    .m_in  (mem_word),
    .x_in  (idx_reg),
    .n_val (n_val),
    .b_sum (b_sum),
    .m_sum (m_sum),
    .x_sum (x_sum)
  );

  skip_test #(.DW(DW), .NSW(NSW), .SEL_W(SEL_W), .SIGNED_CMP(1'b1)) u_tst (
    .op    (op),
    .a     (acc_a),
    .m     (mem_word),
    .ovf   (ovf_latch),
    .sw    (panel_sw),
    .sel   (sel),
    .ptr_b (idx_on_b),
    .b_sum (b_sum),
    .m_sum (m_sum),
    .x_sum (x_sum),
    .res   (res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      skip_cnt  <= 2'd0;
      b_we      <= 1'b0;
      mem_we    <= 1'b0;
      idx_we    <= 1'b0;
      ovf_clr   <= 1'b0;
      b_next    <= '0;
      mem_next  <= '0;
      idx_next  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        skip_cnt <= res.skip;
        b_we     <= res.b_we;
        mem_we   <= res.m_we;
        idx_we   <= res.x_we;
        ovf_clr  <= res.ovf_clr;
        b_next   <= b_sum;
        mem_next <= m_sum;
        idx_next <= x_sum;
      end else begin
        skip_cnt <= 2'd0;
        b_we     <= 1'b0;
        mem_we   <= 1'b0;
        idx_we   <= 1'b0;
        ovf_clr  <= 1'b0;
      end
    end
  end

  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (skip_cnt == 2'd0 && !b_we && !mem_we && !idx_we && !ovf_clr));
  a_r2_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({b_we, mem_we, idx_we, ovf_clr}));
  a_r3_skip_range: assert property (@(posedge clk) disable iff (!rst_n)
    skip_cnt != 2'd3);
  a_r6_clear_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |-> skip_cnt == 2'd0);
  a_r7_b_step: assert property (@(posedge clk) disable iff (!rst_n)
    b_we |-> b_next == $past(acc_b) + DW'(1));
  a_r7_b_sign: assert property (@(posedge clk) disable iff (!rst_n)
    b_we |-> ((skip_cnt == 2'd1) == !b_next[DW-1]));
  a_r8_mem_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((skip_cnt == 2'd1) == (mem_next == '0)));
  a_r10_idx_sign: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |-> ((skip_cnt == 2'd1) == !idx_next[DW-1]));
endmodule

// File: tb/tb_skip_eval.sv
`timescale 1ns/1ps
module tb_skip_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0, acc_a = '0, acc_b = '0, mem_word = '0, idx_reg = '0, panel_sw = '0;
  logic        ovf_latch = 1'b0, idx_on_b = 1'b0;
  logic        out_valid, b_we, mem_we, idx_we, ovf_clr;
  logic [1:0]  skip_cnt;
  logic [15:0] b_next, mem_next, idx_next;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  skip_eval dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .acc_a(acc_a), .acc_b(acc_b), .mem_word(mem_word), .ovf_latch(ovf_latch),
    .panel_sw(panel_sw), .idx_reg(idx_reg), .idx_on_b(idx_on_b),
    .out_valid(out_valid), .skip_cnt(skip_cnt), .b_we(b_we), .b_next(b_next),
    .mem_we(mem_we), .mem_next(mem_next), .idx_we(idx_we), .idx_next(idx_next),
    .ovf_clr(ovf_clr)
  );

  typedef struct {
    int          skip;
    bit          bwe;
    logic [15:0] bn;
    bit          mwe;
    logic [15:0] mn;
    bit          xwe;
    logic [15:0] xn;
    bit          oc;
    string       req;
  } exp_t;

  typedef struct {
    logic [15:0] ins, a, b, m, s, x;
    logic        ov, p;
  } stim_t;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] subfn(input logic [5:0] code, input logic [3:0] n);
    return {6'o00, n, code};
  endfunction

  function automatic exp_t model(input stim_t t);
    exp_t e;
    logic [5:0] maj = t.ins[15:10];
    logic [5:0] sub = t.ins[5:0];
    int sa = int'($signed(t.a));
    int sm = int'($signed(t.m));
    e.skip = 0; e.bwe = 0; e.mwe = 0; e.xwe = 0; e.oc = 0;
    e.bn = t.b + 16'd1; e.mn = t.m + 16'd1; e.xn = t.x + {12'd0, t.ins[9:6]};
    e.req = "R2";
    if (maj == 6'o15) begin
      e.req = "R3"; e.skip = (sa < sm) ? 0 : (sa == sm) ? 1 : 2;
    end else if (maj == 6'o14) begin
      e.req = "R8"; e.mwe = 1; e.skip = (e.mn == 16'd0) ? 1 : 0;
    end else if (maj == 6'o13) begin
      e.req = "R9"; e.skip = t.s[t.ins[3:0]] ? 0 : 1;
    end else if (maj == 6'o00) begin
      case (sub)
        6'o21: begin e.req = "R4"; e.skip = (sa < 0) ? 0 : (sa == 0) ? 1 : 2; end
        6'o22: begin e.req = "R5"; e.skip = (sa == 0) ? 1 : 0; end
        6'o23: begin e.req = "R5"; e.skip = (sa < 0) ? 1 : 0; end
        6'o24: begin e.req = "R5"; e.skip = (sa >= 0) ? 1 : 0; end
        6'o32: begin e.req = "R5"; e.skip = (t.a[15] != t.a[14]) ? 1 : 0; end
        6'o25: begin e.req = "R6"; e.skip = t.ov ? 0 : 1; e.oc = t.ov; end
        6'o26: begin e.req = "R7"; e.bwe = 1; e.skip = e.bn[15] ? 0 : 1; end
        6'o51: begin e.req = "R10"; e.xwe = 1; e.skip = e.xn[15] ? 0 : 1; end
        6'o50: begin e.req = "R11"; e.skip = t.p ? 1 : 0; end
        default: e.req = "R2";
      endcase
    end
    return e;
  endfunction

  task automatic drive(input stim_t t);
    instr = t.ins; acc_a = t.a; acc_b = t.b; mem_word = t.m;
    panel_sw = t.s; idx_reg = t.x; ovf_latch = t.ov; idx_on_b = t.p;
    in_valid = 1'b1;
  endtask

  task automatic check_out(input stim_t t);
    exp_t e = model(t);
    chk(out_valid == 1'b1, "R1", "out_valid", int'(out_valid), 1);
    chk(int'(skip_cnt) == e.skip, e.req, "skip_cnt", int'(skip_cnt), e.skip);
    chk(b_we == e.bwe && mem_we == e.mwe && idx_we == e.xwe && ovf_clr == e.oc, e.req,
        "write enables", int'({b_we, mem_we, idx_we, ovf_clr}), int'({e.bwe, e.mwe, e.xwe, e.oc}));
    if (e.bwe) chk(b_next == e.bn, e.req, "b_next", int'(b_next), int'(e.bn));
    if (e.mwe) chk(mem_next == e.mn, e.req, "mem_next", int'(mem_next), int'(e.mn));
    if (e.xwe) chk(idx_next == e.xn, e.req, "idx_next", int'(idx_next), int'(e.xn));
  endtask

  task automatic run(input stim_t t);
    @(negedge clk); drive(t);
    @(negedge clk); in_valid = 1'b0; check_out(t);
  endtask

  function automatic stim_t mk(input logic [15:0] ins, input logic [15:0] a, input logic [15:0] b,
                               input logic [15:0] m, input logic ov, input logic [15:0] s,
                               input logic [15:0] x, input logic p);
    stim_t t;
    t.ins = ins; t.a = a; t.b = b; t.m = m; t.ov = ov; t.s = s; t.x = x; t.p = p;
    return t;
  endfunction

  function automatic logic [15:0] rnd_word();
    logic [15:0] corners [4] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000};
    if ($urandom % 4 == 0) return corners[$urandom % 4];
    return 16'($urandom);
  endfunction

  function automatic logic [15:0] rnd_instr();
    logic [5:0] subs [9] = '{6'o21, 6'o22, 6'o23, 6'o24, 6'o25, 6'o26, 6'o32, 6'o50, 6'o51};
    logic [15:0] r = 16'($urandom);
    case ($urandom % 6)
      0: return {6'o15, r[9:0]};
      1: return {6'o14, r[9:0]};
      2: return {6'o13, r[9:0]};
      3: return 16'($urandom);
      default: return subfn(subs[$urandom % 9], r[9:6]);
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    stim_t t1, t2;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(out_valid == 0 && skip_cnt == 0, "R12", "valid/skip in reset", int'({out_valid, skip_cnt}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && skip_cnt == 0 && !b_we && !mem_we && !idx_we && !ovf_clr, "R12",
        "idle after reset", int'({out_valid, skip_cnt, b_we, mem_we, idx_we, ovf_clr}), 0);

    // R3: signed compare corners
    run(mk({6'o15, 10'd0}, 16'hFFFF, 0, 16'h0001, 0, 0, 0, 0));
    run(mk({6'o15, 10'd0}, 16'h8000, 0, 16'h7FFF, 0, 0, 0, 0));
    run(mk({6'o15, 10'd0}, 16'h1234, 0, 16'h1234, 0, 0, 0, 0));
    run(mk({6'o15, 10'd0}, 16'h7FFF, 0, 16'h8000, 0, 0, 0, 0));
    // R4: three-way sign
    run(mk(subfn(6'o21, 0), 16'h0000, 0, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o21, 0), 16'h8000, 0, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o21, 0), 16'h0001, 0, 0, 0, 0, 0, 0));
    // R5: single tests, zero counts as positive, normalisation bits
    run(mk(subfn(6'o22, 0), 16'h0000, 0, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o23, 0), 16'h0000, 0, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o24, 0), 16'h0000, 0, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o32, 0), 16'h4000, 0, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o32, 0), 16'hC000, 0, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o32, 0), 16'h8000, 0, 0, 0, 0, 0, 0));
    // R6: overflow test
    run(mk(subfn(6'o25, 0), 0, 0, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o25, 0), 0, 0, 0, 1, 0, 0, 0));
    // R7: increment B
    run(mk(subfn(6'o26, 0), 0, 16'hFFFF, 0, 0, 0, 0, 0));
    run(mk(subfn(6'o26, 0), 0, 16'h7FFF, 0, 0, 0, 0, 0));
    // R8: increment memory, exactly zero only
    run(mk({6'o14, 10'h3FF}, 0, 0, 16'hFFFF, 0, 0, 0, 0));
    run(mk({6'o14, 10'h000}, 0, 0, 16'h0000, 0, 0, 0, 0));
    // R9: sense switch
    run(mk({6'o13, 6'd0, 4'd15}, 0, 0, 0, 0, 16'h8000, 0, 0));
    run(mk({6'o13, 6'd0, 4'd5}, 0, 0, 0, 0, 16'hFFDF, 0, 0));
    run(mk({6'o13, 6'd0, 4'd0}, 0, 0, 0, 0, 16'h0001, 0, 0));
    // R10: index add
    run(mk(subfn(6'o51, 4'd1), 0, 0, 0, 0, 0, 16'hFFFF, 0));
    run(mk(subfn(6'o51, 4'd15), 0, 0, 0, 0, 0, 16'hFFF0, 0));
    run(mk(subfn(6'o51, 4'd0), 0, 0, 0, 0, 0, 16'h0005, 0));
    // R11: index pointer
    run(mk(subfn(6'o50, 0), 0, 0, 0, 0, 0, 0, 1));
    run(mk(subfn(6'o50, 0), 0, 0, 0, 0, 0, 0, 0));
    // R2: unknown codes
    run(mk({6'o05, 10'h3FF}, 16'h0000, 16'hFFFF, 16'hFFFF, 1, 0, 16'hFFFF, 1));
    run(mk(subfn(6'o77, 4'd1), 16'h0000, 16'hFFFF, 16'hFFFF, 1, 0, 16'hFFFF, 1));

    // R1: back-to-back strobes, then idle
    t1 = mk(subfn(6'o26, 0), 0, 16'hFFFF, 0, 0, 0, 0, 0);
    t2 = mk({6'o15, 10'd0}, 16'h0005, 0, 16'h0003, 0, 0, 0, 0);
    @(negedge clk); drive(t1);
    @(negedge clk); check_out(t1); drive(t2);
    @(negedge clk); check_out(t2); in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid after idle", int'(out_valid), 0);
    chk(!b_we && !mem_we && !idx_we && !ovf_clr && skip_cnt == 0, "R2", "idle outputs",
        int'({skip_cnt, b_we, mem_we, idx_we, ovf_clr}), 0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      stim_t t = mk(rnd_instr(), rnd_word(), rnd_word(), rnd_word(), 1'($urandom),
                    16'($urandom), rnd_word(), 1'($urandom));
      if ($urandom % 3 == 0) begin
        @(negedge clk); drive(t);
        @(negedge clk); in_valid = 1'b0; check_out(t);
      end else begin
        run(t);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule